// File: doc/BRIEF.md
# CPU Interrupt Acceptance Controller

This block sequences interrupt entry for an 8-bit processor core. It takes two interrupt inputs:

- A non-maskable request. It is recognised on a falling edge and held until it is serviced.
- A maskable request. It is recognised as a low level.

The block keeps the two enable flags, the maskable-interrupt mode and the vector-page (I) register. The core marks each instruction boundary with `insn_end`. At that point the controller decides whether to take an interrupt, and which one.

After the decision it walks through the steps that the chosen interrupt kind needs:

- an acknowledge bus cycle, with M1 and IORQ low together;
- a request to push the program counter;
- a vector-table read;
- a final load of the new program counter.

In mode 0 it instead tells the core to execute the opcode bytes that the device places on the bus, without advancing the PC.

The core decodes the enable, disable, mode-select and return-from-NMI instructions. It presents each of them to this block as a one-cycle pulse. Stack accesses and the vector-table read are simple request/done handshakes. The core's datapath performs these handshakes and this block does not.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, `iff1`, `iff2`, `int_mode` (00), `pc_value` and the I register are all zero. `m1_n` and `iorq_n` are high. `push_req`, `vrd_req`, `pc_load`, `pop_req` and `mode0_exec` are low.
- R2: A falling edge on `nmi_n` sets a pending flag. The flag stays set, whatever `nmi_n` does afterwards, until an NMI is accepted. Holding `nmi_n` low with no new falling edge causes no second acceptance.
- R3: A pending NMI is accepted at `insn_end`. In that same cycle `take_irq` is high. IFF1 is then copied into IFF2 and IFF1 is cleared. The block raises `push_req` and then pulses `pc_load` with `pc_value` = 0x0066. No acknowledge cycle is run.
- R4: A `retn_pulse` copies IFF2 into IFF1. One cycle later it produces a one-cycle `pop_req`.
- R5: A low `int_n` is accepted at `insn_end` only when IFF1 is 1. Otherwise `take_irq` stays low.
- R6: Accepting the maskable interrupt clears both IFF1 and IFF2. During the acknowledge cycle `m1_n` and `iorq_n` are low together. The cycle lasts one clock, plus one more for every clock in which `wait_n` is low.
- R7: In mode 1 the order is acknowledge, then push, then `pc_load` with 0x0038. The byte on the data bus is ignored.
- R8: In mode 2 the push comes before the acknowledge. Next comes a vector read at address {I, acknowledge byte}. Then `pc_load` delivers the word that was read.
- R9: In mode 0 there is no push. After the acknowledge, `mode0_exec` stays high until the next `insn_end`, and `op_byte` holds the acknowledge byte.
- R10: When an NMI and the maskable interrupt are both pending at a boundary, the NMI is taken.
- R11: `ei_pulse` sets both flags and `di_pulse` clears both. `im_load` with `im_sel` = 0, 1 or 2 selects that mode. `im_sel` = 3 leaves the mode unchanged.
- R12: An `insn_end` that arrives while an entry sequence is still in progress is ignored. Any pending NMI remains latched.
- R13: `ireg_load` loads `ireg_data` into the I register. The I register is the high byte of the mode-2 vector address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensed |
| int_n | input | 1 | Maskable request, active low level |
| wait_n | input | 1 | Device not ready when low (stretches acknowledge) |
| insn_end | input | 1 | Instruction boundary marker from the core |
| ei_pulse | input | 1 | Enable-interrupts instruction pulse |
| di_pulse | input | 1 | Disable-interrupts instruction pulse |
| im_load | input | 1 | Mode-select instruction pulse |
| im_sel | input | 2 | Mode value for `im_load` |
| retn_pulse | input | 1 | Return-from-NMI instruction pulse |
| ireg_load | input | 1 | Load strobe for the I register |
| ireg_data | input | 8 | New I register value |
| data_in | input | 8 | Data bus during acknowledge |
| push_done | input | 1 | PC push completed |
| vrd_done | input | 1 | Vector read completed |
| vrd_data | input | 16 | Word read from the vector table |
| take_irq | output | 1 | Interrupt accepted this cycle |
| push_req | output | 1 | Request to push the PC |
| pop_req | output | 1 | Request to pop the PC (NMI return) |
| vrd_req | output | 1 | Request for a vector-table word read |
| vrd_addr | output | 16 | Vector-table address |
| pc_load | output | 1 | Load `pc_value` into the PC |
| pc_value | output | 16 | New program counter |
| m1_n | output | 1 | Acknowledge cycle marker, active low |
| iorq_n | output | 1 | I/O request during acknowledge, active low |
| mode0_exec | output | 1 | Core executes bus-supplied opcode bytes |
| op_byte | output | 8 | Byte captured during the mode-0 acknowledge |
| iff1 | output | 1 | Interrupt enable flag 1 |
| iff2 | output | 1 | Interrupt enable flag 2 |
| int_mode | output | 2 | Current maskable interrupt mode |

## Verification
The hardest situation to reach is an NMI edge that lands while an earlier entry sequence is still in progress. It has to stay latched through a boundary that is ignored, and then be taken at the next free boundary.

The bench creates this situation in steps:

1. It accepts one NMI.
2. It withholds `push_done` so that the sequencer stays parked in its push step.
3. It drops `nmi_n` again and pulses `insn_end` during the parked step.
4. It releases the push handshake and expects a second NMI entry.

The mode-2 vector address is checked twice, once with the I register still at its reset value and once after it is loaded. The acknowledge stretch is checked by counting the low `iorq_n` cycles for a known number of `wait_n` low cycles.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_ACK,
      ST_VREAD,
      ST_LOAD,
      ST_M0EXEC
   } seq_state_t;

   typedef enum logic [1:0] {
      SRC_NMI,
      SRC_IM0,
      SRC_IM1,
      SRC_IM2
   } irq_src_t;

   typedef logic [1:0] im_mode_t;

   localparam im_mode_t MODE_ZERO = 2'd0;
   localparam im_mode_t MODE_ONE  = 2'd1;
   localparam im_mode_t MODE_TWO  = 2'd2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("irq_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= {STAGES{RST_VAL}};
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_lvl_n,
   input  logic clear,
   output logic pend
);

   logic prev_q;
   logic fall;

   assign fall = prev_q & ~nmi_lvl_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend   <= 1'b0;
      end else begin
         prev_q <= nmi_lvl_n;
         pend   <= fall | (pend & ~clear);
      end
   end

   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clear) |=> pend); // R2

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && clear && nmi_lvl_n) |=> !pend); // R2

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
   import irq_accept_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_nmi,
   input  logic              take_int,
   input  logic              ei_pulse,
   input  logic              di_pulse,
   input  logic              im_load,
   input  logic [1:0]        im_sel,
   input  logic              retn_pulse,
   input  logic              ireg_load,
   input  logic [DATA_W-1:0] ireg_data,
   output logic              iff1,
   output logic              iff2,
   output im_mode_t          mode,
   output logic              pop_req,
   output logic [DATA_W-1:0] ireg
);

   generate
      if (DATA_W < 4) begin : g_bad
         $error("irq_enable_regs: DATA_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (take_nmi) begin
         iff2 <= iff1;
         iff1 <= 1'b0;
      end else if (take_int || di_pulse) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (ei_pulse) begin
         iff1 <= 1'b1;
         iff2 <= 1'b1;
      end else if (retn_pulse) begin
         iff1 <= iff2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_ZERO;
      end else if (im_load && im_sel != 2'd3) begin
         mode <= im_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_req <= 1'b0;
         ireg    <= '0;
      end else begin
         pop_req <= retn_pulse;
         if (ireg_load) begin
            ireg <= ireg_data;
         end
      end
   end

   AST_NMI_SAVES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      take_nmi |=> (!iff1 && iff2 == $past(iff1))); // R3

   AST_INT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_int && !take_nmi) |=> (!iff1 && !iff2)); // R6

   AST_RETN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (retn_pulse && !take_nmi && !take_int && !di_pulse && !ei_pulse)
         |=> (iff1 == $past(iff2))); // R4

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3); // R11

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_accept_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter int                DATA_W  = 8,
   parameter logic [ADDR_W-1:0] NMI_VEC = 'h0066,
   parameter logic [ADDR_W-1:0] IM1_VEC = 'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_end,
   input  logic              nmi_pend,
   input  logic              int_lvl_n,
   input  logic              iff1,
   input  im_mode_t          mode,
   input  logic [DATA_W-1:0] ireg,
   input  logic              wait_n,
   input  logic [DATA_W-1:0] data_in,
   input  logic              push_done,
   input  logic              vrd_done,
   input  logic [ADDR_W-1:0] vrd_data,
   output logic              take_nmi,
   output logic              take_int,
   output logic              push_req,
   output logic              vrd_req,
   output logic [ADDR_W-1:0] vrd_addr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              m1_n,
   output logic              iorq_n,
   output logic              mode0_exec,
   output logic [DATA_W-1:0] op_byte
);

   generate
      if (NMI_VEC == IM1_VEC) begin : g_bad_vec
         $error("irq_seq: the two fixed vectors must differ");
      end
   endgenerate

   seq_state_t        state;
   irq_src_t          src;
   irq_src_t          int_src;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] byte_q;
   logic              idle;

   assign idle     = (state == ST_IDLE);
   assign take_nmi = idle && insn_end && nmi_pend;
   assign take_int = idle && insn_end && !nmi_pend && !int_lvl_n && iff1;

   always_comb begin
      case (mode)
         MODE_ONE: int_src = SRC_IM1;
         MODE_TWO: int_src = SRC_IM2;
         default:  int_src = SRC_IM0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         src    <= SRC_NMI;
         pc_q   <= '0;
         byte_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (take_nmi) begin
                  src   <= SRC_NMI;
                  state <= ST_PUSH;
               end else if (take_int) begin
                  src   <= int_src;
                  state <= (int_src == SRC_IM2) ? ST_PUSH : ST_ACK;
               end
            end
            ST_PUSH: begin
               if (push_done) begin
                  if (src == SRC_IM2) begin
                     state <= ST_ACK;
                  end else begin
                     pc_q  <= (src == SRC_NMI) ? NMI_VEC : IM1_VEC;
                     state <= ST_LOAD;
                  end
               end
            end
            ST_ACK: begin
               if (wait_n) begin
                  if (src != SRC_IM1) begin
                     byte_q <= data_in;
                  end
                  case (src)
                     SRC_IM1: state <= ST_PUSH;
                     SRC_IM2: state <= ST_VREAD;
                     default: state <= ST_M0EXEC;
                  endcase
               end
            end
            ST_VREAD: begin
               if (vrd_done) begin
                  pc_q  <= vrd_data;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: state <= ST_IDLE;
            ST_M0EXEC: begin
               if (insn_end) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign push_req   = (state == ST_PUSH);
   assign vrd_req    = (state == ST_VREAD);
   assign vrd_addr   = {ireg, byte_q};
   assign pc_load    = (state == ST_LOAD);
   assign pc_value   = pc_q;
   assign m1_n       = (state != ST_ACK);
   assign iorq_n     = (state != ST_ACK);
   assign mode0_exec = (state == ST_M0EXEC);
   assign op_byte    = byte_q;

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({push_req, vrd_req, !iorq_n, pc_load, mode0_exec}) <= 1); // R8

   AST_TAKE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_nmi || take_int) |=> !idle); // R12

   AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorq_n && !wait_n) |=> !iorq_n); // R6

   AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && src == SRC_NMI) |-> pc_value == NMI_VEC); // R3

   AST_NMI_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_NMI) |-> iorq_n); // R3

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
   import irq_accept_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] NMI_VEC     = 'h0066,
   parameter logic [ADDR_W-1:0] IM1_VEC     = 'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_n,
   input  logic              int_n,
   input  logic              wait_n,
   input  logic              insn_end,
   input  logic              ei_pulse,
   input  logic              di_pulse,
   input  logic              im_load,
   input  logic [1:0]        im_sel,
   input  logic              retn_pulse,
   input  logic              ireg_load,
   input  logic [DATA_W-1:0] ireg_data,
   input  logic [DATA_W-1:0] data_in,
   input  logic              push_done,
   input  logic              vrd_done,
   input  logic [ADDR_W-1:0] vrd_data,
   output logic              take_irq,
   output logic              push_req,
   output logic              pop_req,
   output logic              vrd_req,
   output logic [ADDR_W-1:0] vrd_addr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              m1_n,
   output logic              iorq_n,
   output logic              mode0_exec,
   output logic [DATA_W-1:0] op_byte,
   output logic              iff1,
   output logic              iff2,
   output logic [1:0]        int_mode
);

   localparam int VEC_HALF = ADDR_W / 2;

   generate
      if (VEC_HALF != DATA_W || (ADDR_W % 2) != 0) begin : g_bad_width
         $error("irq_accept_ctrl: ADDR_W must be twice DATA_W");
      end
   endgenerate

   logic     nmi_s_n;
   logic     int_s_n;
   logic     nmi_pend;
   logic     take_nmi;
   logic     take_int;
   im_mode_t mode;
   logic [DATA_W-1:0] ireg;

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
      .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_s_n)
   );

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_int (
      .clk(clk), .rst_n(rst_n), .d(int_n), .q(int_s_n)
   );

   irq_nmi_edge u_nmi_edge (
      .clk(clk), .rst_n(rst_n), .nmi_lvl_n(nmi_s_n),
      .clear(take_nmi), .pend(nmi_pend)
   );

   irq_enable_regs #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .take_nmi(take_nmi), .take_int(take_int),
      .ei_pulse(ei_pulse), .di_pulse(di_pulse),
      .im_load(im_load), .im_sel(im_sel),
      .retn_pulse(retn_pulse),
      .ireg_load(ireg_load), .ireg_data(ireg_data),
      .iff1(iff1), .iff2(iff2), .mode(mode),
      .pop_req(pop_req), .ireg(ireg)
   );

   irq_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .NMI_VEC(NMI_VEC), .IM1_VEC(IM1_VEC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .insn_end(insn_end), .nmi_pend(nmi_pend), .int_lvl_n(int_s_n),
      .iff1(iff1), .mode(mode), .ireg(ireg),
      .wait_n(wait_n), .data_in(data_in),
      .push_done(push_done), .vrd_done(vrd_done), .vrd_data(vrd_data),
      .take_nmi(take_nmi), .take_int(take_int),
      .push_req(push_req), .vrd_req(vrd_req), .vrd_addr(vrd_addr),
      .pc_load(pc_load), .pc_value(pc_value),
      .m1_n(m1_n), .iorq_n(iorq_n),
      .mode0_exec(mode0_exec), .op_byte(op_byte)
   );

   assign take_irq = take_nmi | take_int;
   assign int_mode = mode;

   AST_PRIORITY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_nmi && take_int)); // R10

   AST_INT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && !nmi_pend) |-> iff1); // R5

endmodule

// File: tb/irq_accept_ctrl_bench.sv
`timescale 1ns/1ps
module irq_accept_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_n = 1'b1, int_n = 1'b1, wait_n = 1'b1, insn_end = 1'b0;
   logic        ei_pulse = 1'b0, di_pulse = 1'b0, im_load = 1'b0, retn_pulse = 1'b0;
   logic [1:0]  im_sel = 2'd0;
   logic        ireg_load = 1'b0;
   logic [7:0]  ireg_data = 8'h00, data_in = 8'h00;
   logic        push_done = 1'b0, vrd_done = 1'b0;
   logic [15:0] vrd_data = 16'h0000;
   logic        take_irq, push_req, pop_req, vrd_req, pc_load, m1_n, iorq_n, mode0_exec;
   logic [15:0] vrd_addr, pc_value;
   logic [7:0]  op_byte;
   logic        iff1, iff2;
   logic [1:0]  int_mode;

   int vectors = 0;
   int miscompares = 0;

   always #10 clk = ~clk;

   irq_accept_ctrl u_irq_accept_ctrl (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n), .wait_n(wait_n),
      .insn_end(insn_end), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
      .im_load(im_load), .im_sel(im_sel), .retn_pulse(retn_pulse),
      .ireg_load(ireg_load), .ireg_data(ireg_data), .data_in(data_in),
      .push_done(push_done), .vrd_done(vrd_done), .vrd_data(vrd_data),
      .take_irq(take_irq), .push_req(push_req), .pop_req(pop_req),
      .vrd_req(vrd_req), .vrd_addr(vrd_addr), .pc_load(pc_load),
      .pc_value(pc_value), .m1_n(m1_n), .iorq_n(iorq_n),
      .mode0_exec(mode0_exec), .op_byte(op_byte),
      .iff1(iff1), .iff2(iff2), .int_mode(int_mode)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_s(input string req, input string what,
                        input string act, input string exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual \"%s\" expected \"%s\"", req, what, act, exp);
      end
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk); im_sel = m; im_load = 1'b1;
      @(negedge clk); im_load = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // drive one boundary marker; returns take_irq seen in that cycle
   task automatic boundary(output logic took);
      @(negedge clk); insn_end = 1'b1;
      #2 took = take_irq;
      @(negedge clk); insn_end = 1'b0;
   endtask

   // answers the handshakes, records the order of steps
   task automatic serve(input logic [7:0] ack_byte, input int ack_waits,
                        input logic [15:0] vec_word,
                        output string order, output logic [15:0] pc_got,
                        output logic [15:0] vaddr, output int ack_cycles);
      int waits_left = ack_waits;
      string last = "";
      order = ""; pc_got = 16'hxxxx; vaddr = 16'hxxxx; ack_cycles = 0;
      for (int i = 0; i < 40; i++) begin
         string c = "";
         #1;
         push_done = 1'b0; vrd_done = 1'b0; wait_n = 1'b1;
         if (push_req) begin c = "P"; push_done = 1'b1; end
         if (!iorq_n) begin
            c = "A"; ack_cycles++;
            chk("R6", "m1_n low with iorq_n", {31'd0, m1_n}, 32'd0);
            data_in = ack_byte;
            if (waits_left > 0) begin wait_n = 1'b0; waits_left--; end
         end
         if (vrd_req) begin
            c = "V"; vaddr = vrd_addr; vrd_data = vec_word; vrd_done = 1'b1;
         end
         if (pc_load) c = "L";
         if (mode0_exec) c = "X";
         if (c != "" && c != last) begin order = {order, c}; last = c; end
         if (pc_load) begin pc_got = pc_value; break; end
         if (mode0_exec) break;
         @(negedge clk);
      end
      @(negedge clk);
      push_done = 1'b0; vrd_done = 1'b0; wait_n = 1'b1;
   endtask

   task automatic t_reset;
      chk("R1", "iff1", {31'd0, iff1}, 0);
      chk("R1", "iff2", {31'd0, iff2}, 0);
      chk("R1", "mode", {30'd0, int_mode}, 0);
      chk("R1", "pc_value", {16'd0, pc_value}, 0);
      chk("R1", "m1_n/iorq_n", {30'd0, m1_n, iorq_n}, 32'd3);
      chk("R1", "requests", {27'd0, push_req, vrd_req, pc_load, pop_req, mode0_exec}, 0);
   endtask

   task automatic t_controls;
      pulse(ei_pulse);
      chk("R11", "ei flags", {30'd0, iff1, iff2}, 32'd3);
      pulse(di_pulse);
      chk("R11", "di flags", {30'd0, iff1, iff2}, 32'd0);
      set_mode(2'd1);
      chk("R11", "mode 1", {30'd0, int_mode}, 32'd1);
      set_mode(2'd3);
      chk("R11", "mode 3 ignored", {30'd0, int_mode}, 32'd1);
      set_mode(2'd2);
      chk("R11", "mode 2", {30'd0, int_mode}, 32'd2);
      set_mode(2'd0);
      chk("R11", "mode 0", {30'd0, int_mode}, 32'd0);
   endtask

   task automatic t_int_disabled;
      logic took;
      pulse(di_pulse);
      set_mode(2'd1);
      int_n = 1'b0;
      idle_cycles(4);
      boundary(took);
      chk("R5", "int with iff1=0", {31'd0, took}, 0);
      idle_cycles(2);
      chk("R5", "no step started", {29'd0, push_req, !iorq_n, pc_load}, 0);
      int_n = 1'b1;
      idle_cycles(3);
   endtask

   task automatic t_nmi_and_return;
      logic took; string ord; logic [15:0] pc, va; int ac;
      pulse(ei_pulse);
      nmi_n = 1'b0;
      idle_cycles(6);
      boundary(took);
      chk("R3", "take on nmi", {31'd0, took}, 1);
      chk("R3", "iff after nmi", {30'd0, iff1, iff2}, 32'd1);
      serve(8'h00, 0, 16'h0, ord, pc, va, ac);
      chk_s("R3", "nmi order", ord, "PL");
      chk("R3", "nmi vector", {16'd0, pc}, 32'h0066);
      boundary(took);
      chk("R2", "held low no retrigger", {31'd0, took}, 0);
      nmi_n = 1'b1;
      @(negedge clk); retn_pulse = 1'b1;
      @(negedge clk); retn_pulse = 1'b0;
      chk("R4", "iff1 restored", {30'd0, iff1, iff2}, 32'd3);
      chk("R4", "pop pulse", {31'd0, pop_req}, 1);
      @(negedge clk);
      chk("R4", "pop one cycle", {31'd0, pop_req}, 0);
   endtask

   task automatic t_nmi_latched;
      logic took; string ord; logic [15:0] pc, va; int ac;
      nmi_n = 1'b0;
      idle_cycles(4);
      nmi_n = 1'b1;
      idle_cycles(10);
      boundary(took);
      chk("R2", "latched edge taken later", {31'd0, took}, 1);
      serve(8'h00, 0, 16'h0, ord, pc, va, ac);
      chk("R2", "latched nmi vector", {16'd0, pc}, 32'h0066);
   endtask

   task automatic t_mode1;
      logic took; string ord; logic [15:0] pc, va; int ac;
      pulse(ei_pulse);
      set_mode(2'd1);
      int_n = 1'b0;
      idle_cycles(4);
      boundary(took);
      chk("R5", "int taken with iff1=1", {31'd0, took}, 1);
      chk("R6", "iff cleared", {30'd0, iff1, iff2}, 0);
      serve(8'hFF, 2, 16'h0, ord, pc, va, ac);
      chk_s("R7", "mode1 order", ord, "APL");
      chk("R7", "mode1 vector", {16'd0, pc}, 32'h0038);
      chk("R6", "ack stretched by 2 waits", ac, 3);
      int_n = 1'b1;
      idle_cycles(3);
   endtask

   task automatic t_mode2(input logic [7:0] ival, input logic [7:0] lo,
                          input logic [15:0] word, input string req);
      logic took; string ord; logic [15:0] pc, va; int ac;
      pulse(ei_pulse);
      set_mode(2'd2);
      int_n = 1'b0;
      idle_cycles(4);
      boundary(took);
      chk("R8", "mode2 take", {31'd0, took}, 1);
      serve(lo, 0, word, ord, pc, va, ac);
      chk_s("R8", "mode2 order", ord, "PAVL");
      chk(req, "vector address", {16'd0, va}, {16'd0, ival, lo});
      chk("R8", "mode2 pc", {16'd0, pc}, {16'd0, word});
      chk("R6", "single ack cycle", ac, 1);
      int_n = 1'b1;
      idle_cycles(3);
   endtask

   task automatic t_mode0;
      logic took; string ord; logic [15:0] pc, va; int ac;
      pulse(ei_pulse);
      set_mode(2'd0);
      int_n = 1'b0;
      idle_cycles(4);
      boundary(took);
      chk("R9", "mode0 take", {31'd0, took}, 1);
      serve(8'hC7, 1, 16'h0, ord, pc, va, ac);
      int_n = 1'b1;
      chk_s("R9", "mode0 order no push", ord, "AX");
      chk("R9", "op byte", {24'd0, op_byte}, 32'hC7);
      idle_cycles(3);
      chk("R9", "exec held", {31'd0, mode0_exec}, 1);
      boundary(took);
      chk("R9", "exec ends at boundary", {31'd0, mode0_exec}, 0);
      chk("R12", "no take during exec", {31'd0, took}, 0);
      idle_cycles(3);
   endtask

   task automatic t_priority;
      logic took; string ord; logic [15:0] pc, va; int ac;
      pulse(ei_pulse);
      set_mode(2'd1);
      int_n = 1'b0;
      nmi_n = 1'b0;
      idle_cycles(6);
      boundary(took);
      chk("R10", "take with both", {31'd0, took}, 1);
      chk("R10", "nmi path flags", {30'd0, iff1, iff2}, 32'd1);
      serve(8'h00, 0, 16'h0, ord, pc, va, ac);
      chk_s("R10", "nmi order wins", ord, "PL");
      chk("R10", "nmi vector wins", {16'd0, pc}, 32'h0066);
      boundary(took);
      chk("R10", "int blocked after nmi", {31'd0, took}, 0);
      int_n = 1'b1;
      nmi_n = 1'b1;
      idle_cycles(3);
   endtask

   task automatic t_busy;
      logic took; string ord; logic [15:0] pc, va; int ac;
      nmi_n = 1'b0;
      idle_cycles(6);
      boundary(took);
      chk("R12", "first nmi", {31'd0, took}, 1);
      nmi_n = 1'b1;
      idle_cycles(2);
      nmi_n = 1'b0;
      idle_cycles(6);
      chk("R12", "still parked in push", {31'd0, push_req}, 1);
      boundary(took);
      chk("R12", "boundary ignored while busy", {31'd0, took}, 0);
      serve(8'h00, 0, 16'h0, ord, pc, va, ac);
      chk_s("R12", "first nmi finishes", ord, "PL");
      boundary(took);
      chk("R12", "second nmi kept latched", {31'd0, took}, 1);
      serve(8'h00, 0, 16'h0, ord, pc, va, ac);
      chk("R12", "second nmi vector", {16'd0, pc}, 32'h0066);
      nmi_n = 1'b1;
      idle_cycles(3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_controls();
      t_int_disabled();
      t_nmi_and_return();
      t_nmi_latched();
      t_mode1();
      t_mode2(8'h00, 8'h24, 16'hBEEF, "R1");
      @(negedge clk); ireg_data = 8'h81; ireg_load = 1'b1;
      @(negedge clk); ireg_load = 1'b0;
      t_mode2(8'h81, 8'h10, 16'h1234, "R13");
      t_mode0();
      t_priority();
      t_busy();
      report();
      $finish;
   end

endmodule